// File: doc/BRIEF.md
# Cache Miss Refill Engine with Selectable Word Order

This block fills one cache line after a miss. It sits between the cache and a lower memory level. When a miss is accepted it fetches every word of the block over a memory port that carries one word at a time. It writes each returned word into the line storage. When the word the processor asked for arrives, the engine passes it to the processor in that same cycle, and it does not wait for the rest of the block.

A mode bit, sampled with the miss, sets the fetch order. In critical-first mode (`miss_cwf` = 1) the engine requests the missed word first and then the following words, wrapping at the end of the block. In ascending mode (`miss_cwf` = 0) it requests the words from word 0 upward. In that mode the missed word still goes to the processor as soon as it arrives. The engine keeps one memory request outstanding at a time. It moves on only when the port accepts the request (`mem_req_ready`) and when the response is valid (`mem_rsp_valid`). The cache does the tag lookup and picks the line to replace before it raises a miss.

The controller has four states:
- `ST_IDLE`: waiting for a miss.
- `ST_ISSUE`: presenting a word request.
- `ST_AWAIT`: waiting for the response word.
- `ST_SEAL`: one cycle that marks the line valid.

The transitions are:
- `ST_IDLE`→`ST_ISSUE` when a miss is accepted.
- `ST_ISSUE`→`ST_AWAIT` when `mem_req_ready` is high.
- `ST_AWAIT`→`ST_ISSUE` when a response arrives and words remain.
- `ST_AWAIT`→`ST_SEAL` on the response for the last word.
- `ST_SEAL`→`ST_IDLE` unconditionally.

Top module: `line_refill_engine`

## Requirements
- R1: After reset, and after a reset applied in the middle of a fill, the outputs `busy`, `mem_req_valid`, `line_wr_en`, `cpu_valid` and `line_valid` are all 0.
- R2: An accepted miss produces exactly 4 word requests, one for each word of the block, and no further request follows. `mem_req_addr` is the block address in the upper 8 bits and the word offset in the low 2 bits.
- R3: When `miss_cwf` = 1, the requested offsets are o, o+1, o+2, o+3 taken modulo 4, where o is `miss_off`.
- R4: When `miss_cwf` = 0, the requested offsets are 0, 1, 2, 3 whatever `miss_off` is.
- R5: Each valid response is written in its own cycle: `line_wr_en` = 1, `line_wr_off` = the offset just requested, `line_wr_data` = `mem_rsp_data`, and `line_wr_blk` = the block address of the miss.
- R6: `cpu_valid` is high for exactly one cycle per miss. That cycle is the one in which the response for `miss_off` is valid, and `cpu_data` then equals that response data.
- R7: `busy` is high from the cycle after the miss is accepted up to and including the `line_valid` cycle. A `miss_valid` raised while `busy` is high is ignored: the block address and order of the fill in progress do not change, and no new fill starts.
- R8: `line_valid` is a one-cycle pulse in the cycle after the last word is written. It is never high earlier in the fill.
- R9: While `mem_req_ready` is low, the request stays up with an unchanged address. While `mem_rsp_valid` is low, nothing is written and the engine does not advance, however many cycles the stall lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request; accepted only when not busy |
| miss_blk | input | 8 | Block address of the miss |
| miss_off | input | 2 | Offset of the missed word in the block |
| miss_cwf | input | 1 | 1 = critical-first order, 0 = ascending order |
| busy | output | 1 | A fill is in progress |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 10 | {block, word offset} of the request |
| mem_rsp_valid | input | 1 | Response word is valid |
| mem_rsp_data | input | 32 | Response word |
| line_wr_en | output | 1 | Write strobe to line storage |
| line_wr_blk | output | 8 | Block address being filled |
| line_wr_off | output | 2 | Word offset being written |
| line_wr_data | output | 32 | Word being written |
| line_valid | output | 1 | Pulse that marks the filled line valid |
| cpu_valid | output | 1 | Missed word forwarded to the processor |
| cpu_data | output | 32 | Forwarded word |

## Verification
The assertions assume that the memory port never returns a response unless a request has been accepted and is still outstanding. They also assume that `mem_rsp_valid` is a single-cycle pulse for each word. The bench models the memory procedurally, one request at a time. It raises `mem_rsp_valid` only in the wait state, after the request handshake and after a programmable stall, and drops it after one cycle. It varies the request and response stalls and raises a miss while busy only as a deliberate test.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2,
        ST_SEAL  = 2'd3
    } fill_state_t;
endpackage

// File: rtl/refill_order.sv
module refill_order #(
    parameter int WORDS = 4,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             wrap_mode,
    input  logic [OFF_W-1:0] crit_off,
    input  logic [OFF_W-1:0] step,
    output logic [OFF_W-1:0] word_off
);
    logic [OFF_W-1:0] wrapped;

    generate
        if ((1 << OFF_W) == WORDS) begin : g_pow2
            assign wrapped = crit_off + step;
        end else begin : g_mod
            logic [OFF_W:0] sum;
            assign sum     = {1'b0, crit_off} + {1'b0, step};
            assign wrapped = (sum >= (OFF_W+1)'(WORDS)) ? OFF_W'(sum - (OFF_W+1)'(WORDS))
                                                        : sum[OFF_W-1:0];
        end
    endgenerate

    assign word_off = wrap_mode ? wrapped : step;
endmodule

// File: rtl/refill_fwd.sv
module refill_fwd #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fill_done,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  crit_off,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data
);
    logic fwd_seen;

    assign cpu_valid = wr_en && (wr_off == crit_off);
    assign cpu_data  = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         fwd_seen <= 1'b0;
        else if (start)     fwd_seen <= 1'b0;
        else if (cpu_valid) fwd_seen <= 1'b1;
    end

    // R6
    single_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> !fwd_seen);

    // R6
    fwd_before_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> fwd_seen);
endmodule

// File: rtl/line_refill_engine.sv
module line_refill_engine
    import refill_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int BLK_W  = 8,
    parameter int DATA_W = 32,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [BLK_W-1:0]  miss_blk,
    input  logic [OFF_W-1:0]  miss_off,
    input  logic              miss_cwf,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              line_wr_en,
    output logic [BLK_W-1:0]  line_wr_blk,
    output logic [OFF_W-1:0]  line_wr_off,
    output logic [DATA_W-1:0] line_wr_data,
    output logic              line_valid,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data
);
    localparam logic [OFF_W-1:0] LAST_STEP = OFF_W'(WORDS - 1);

    fill_state_t      state_q, state_d;
    logic [OFF_W-1:0] step_q;
    logic [BLK_W-1:0] blk_q;
    logic [OFF_W-1:0] off_q;
    logic             cwf_q;
    logic [OFF_W-1:0] cur_off;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && miss_valid;

    refill_order #(.WORDS(WORDS)) u_order (
        .wrap_mode (cwf_q),
        .crit_off  (off_q),
        .step      (step_q),
        .word_off  (cur_off)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid)    state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_AWAIT;
            ST_AWAIT: if (mem_rsp_valid) state_d = (step_q == LAST_STEP) ? ST_SEAL : ST_ISSUE;
            ST_SEAL:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            blk_q   <= '0;
            off_q   <= '0;
            cwf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                step_q <= '0;
                blk_q  <= miss_blk;
                off_q  <= miss_off;
                cwf_q  <= miss_cwf;
            end else if ((state_q == ST_AWAIT) && mem_rsp_valid && (step_q != LAST_STEP)) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = {blk_q, cur_off};
        line_wr_en    = (state_q == ST_AWAIT) && mem_rsp_valid;
        line_wr_blk   = blk_q;
        line_wr_off   = cur_off;
        line_wr_data  = mem_rsp_data;
        line_valid    = (state_q == ST_SEAL);
    end

    refill_fwd #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .fill_done (line_valid),
        .wr_en     (line_wr_en),
        .wr_off    (line_wr_off),
        .wr_data   (line_wr_data),
        .crit_off  (off_q),
        .cpu_valid (cpu_valid),
        .cpu_data  (cpu_data)
    );

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && miss_valid) |=> ($stable(blk_q) && $stable(off_q) && $stable(cwf_q)));

    // R3
    crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && cwf_q && step_q == '0) |-> (mem_req_addr[OFF_W-1:0] == off_q));

    // R4
    ascend_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !cwf_q) |-> (mem_req_addr[OFF_W-1:0] == step_q));

    // R8
    seal_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> ($past(line_wr_en) && $past(step_q) == LAST_STEP));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_AWAIT) && !mem_rsp_valid) |=> ((state_q == ST_AWAIT) && $stable(step_q)));
endmodule

// File: tb/sim_line_refill_engine.sv
`timescale 1ns/1ps
module sim_line_refill_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [7:0]  miss_blk = '0;
    logic [1:0]  miss_off = '0;
    logic        miss_cwf = 1'b0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [9:0]  mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        line_wr_en;
    logic [7:0]  line_wr_blk;
    logic [1:0]  line_wr_off;
    logic [31:0] line_wr_data;
    logic        line_valid;
    logic        cpu_valid;
    logic [31:0] cpu_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    line_refill_engine u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
        .miss_off(miss_off), .miss_cwf(miss_cwf), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .line_wr_en(line_wr_en),
        .line_wr_blk(line_wr_blk), .line_wr_off(line_wr_off),
        .line_wr_data(line_wr_data), .line_valid(line_valid),
        .cpu_valid(cpu_valid), .cpu_data(cpu_data)
    );

    // vector: {poke[15], rsp_stall[14:13], req_stall[12:11], cwf[10], off[9:8], blk[7:0]}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 8'h3C},
        {1'b0, 2'd0, 2'd0, 1'b0, 2'd2, 8'h3C},
        {1'b0, 2'd2, 2'd1, 1'b1, 2'd3, 8'hA1},
        {1'b0, 2'd3, 2'd3, 1'b0, 2'd3, 8'h07},
        {1'b0, 2'd1, 2'd2, 1'b1, 2'd0, 8'hFF},
        {1'b0, 2'd0, 2'd1, 1'b0, 2'd0, 8'h00},
        {1'b1, 2'd2, 2'd0, 1'b1, 2'd1, 8'h5A},
        {1'b1, 2'd1, 2'd1, 1'b0, 2'd1, 8'h96}
    };

    function automatic logic [31:0] word_of(input logic [7:0] b, input logic [1:0] o);
        return {8'hD0, b, 14'h1234, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_miss(input logic [15:0] v);
        logic [7:0] b;
        logic [1:0] o;
        logic       cwf;
        int         rqs, rss, fwd_cnt;
        logic [1:0] exp_off;
        b = v[7:0]; o = v[9:8]; cwf = v[10]; rqs = int'(v[12:11]); rss = int'(v[14:13]);
        fwd_cnt = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_blk = b; miss_off = o; miss_cwf = cwf;
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R7 busy after accept", 32'(busy), 32'd1);
        for (int k = 0; k < 4; k++) begin
            exp_off = cwf ? 2'(o + 2'(k)) : 2'(k);
            for (int s = 0; s < rqs; s++) begin
                mem_req_ready = 1'b0;
                #1;
                chk("R9 request held", 32'({mem_req_valid, mem_req_addr}), 32'({1'b1, b, exp_off}));
                @(negedge clk);
            end
            mem_req_ready = 1'b1;
            #1;
            chk(cwf ? "R3 request order" : "R4 request order",
                32'({mem_req_valid, mem_req_addr}), 32'({1'b1, b, exp_off}));
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int s = 0; s < rss; s++) begin
                if (v[15] && k == 1 && s == 0) begin
                    miss_valid = 1'b1; miss_blk = ~b; miss_off = o + 2'd1; miss_cwf = ~cwf;
                end
                #1;
                chk("R9 no write while stalled", 32'({line_wr_en, cpu_valid, line_valid}), 32'd0);
                @(negedge clk);
                miss_valid = 1'b0;
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = word_of(b, exp_off);
            #1;
            chk("R5 line write", 32'({line_wr_en, line_wr_blk, line_wr_off}), 32'({1'b1, b, exp_off}));
            chk("R5 line data", line_wr_data, word_of(b, exp_off));
            chk("R6 forward strobe", 32'(cpu_valid), 32'(exp_off == o));
            chk("R8 no early valid", 32'(line_valid), 32'd0);
            if (cpu_valid) begin
                fwd_cnt++;
                chk("R6 forward data", cpu_data, word_of(b, o));
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        #1;
        chk("R8 line valid pulse", 32'({line_valid, busy}), 32'b11);
        chk("R6 one forward per miss", 32'(fwd_cnt), 32'd1);
        @(negedge clk);
        #1;
        chk("R7 busy drops after seal", 32'({busy, line_valid}), 32'd0);
        chk("R2 no fifth request", 32'(mem_req_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        #1;
        chk("R1 reset outputs", 32'({busy, mem_req_valid, line_wr_en, cpu_valid, line_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 idle after reset", 32'({busy, mem_req_valid}), 32'd0);

        foreach (VEC[i]) run_miss(VEC[i]);

        // R1: reset in the middle of a fill
        @(negedge clk);
        miss_valid = 1'b1; miss_blk = 8'h44; miss_off = 2'd1; miss_cwf = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        mem_req_ready = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 mid-fill reset", 32'({busy, mem_req_valid, line_wr_en, cpu_valid, line_valid}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 stays idle", 32'({busy, mem_req_valid}), 32'd0);

        // R6/R4: missed word is the last in ascending order
        run_miss({1'b0, 2'd0, 2'd0, 1'b0, 2'd3, 8'hE2});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule